// File: doc/BRIEF.md
# Configuration-Space Serial EEPROM Bridge

This block gives software access to a small serial configuration EEPROM without dedicated pins. Software drives the EEPROM by writing bytes into the adapter's configuration space. A byte write to the control offset sets the serial clock and data-in lines and asserts chip select. A byte write to the release offset drops all three lines. The EEPROM's data-out line is read back in bit 0 of configuration byte 0. On a single-byte read of that offset, the value that the rest of configuration space supplies has its low bit ANDed with data-out.

The EEPROM is modelled inside the block. It is a 64-word by 16-bit serial part that answers only the read command. Its contents come from a fixed power-on image, and the last word of that image is a checksum chosen so that all 64 words add up to 0x1234.

The serial machine has eight states:
- ST_DESEL: chip select is low.
- ST_START: waiting for the start bit.
- ST_OPCODE: two opcode bits.
- ST_ADDR: six address bits.
- ST_DUMMY: the leading 0 on data-out.
- ST_DATA: sixteen data bits.
- ST_DONE: the word is finished.
- ST_IGNORE: the opcode was not a read.

Transitions:
- Dropping chip select moves any state to ST_DESEL.
- ST_DESEL goes to ST_START, or straight to ST_OPCODE when the enabling write also carries a rising clock with data-in high.
- ST_START goes to ST_OPCODE on a sampled 1.
- ST_OPCODE goes to ST_ADDR for opcode 10, and to ST_IGNORE for any other opcode.
- ST_ADDR goes to ST_DUMMY on the sixth address bit.
- ST_DUMMY goes to ST_DATA on the next rising edge.
- ST_DATA goes to ST_DONE on the rising edge after the last bit.

Top module: `cfg_eeprom_bridge`

## Requirements
- R1: A byte write to offset 0x80 asserts chip select and sets the serial clock from data bit 7 and data-in from data bit 6.
- R2: A byte write to offset 0xC0 deasserts chip select and drives the clock and data-in low.
- R3: A single-byte read of offset 0x00 returns bits 7:1 of the supplied value unchanged, and bit 0 as the supplied bit 0 ANDed with EEPROM data-out.
- R4: Every other read returns the supplied value unchanged: another offset, or a read wider than one byte.
- R5: A read command is a 1 start bit, opcode bits 1 then 0, and six address bits with the MSB first. Each bit is sampled on a rising serial clock. Data-out then shows a 0, and the word's 16 bits follow MSB first, each advanced by one further rising clock.
- R6: Zeros clocked in before the start bit are ignored.
- R7: Rising edges are found against the last written clock level, so repeated writes with the clock high do not advance the sequence.
- R8: Dropping chip select abandons any sequence in progress. Data-out is 1 whenever it is not driving the dummy bit or a data bit.
- R9: An opcode other than 10 leaves data-out at 1 until chip select drops.
- R10: The power-on image is as follows. Words 0 to 15 hold 0x0057. Word 32 holds 0x0007 (bytes 64 and 65). Word 33 holds 0x040F (byte 66 is 0x0F, byte 67 is 0x04). Word 34 holds 0x0007. Word 63 holds the checksum 0x08A7. All other words are zero, and the 16-bit sum of all 64 words is 0x1234.
- R11: After reset, chip select is low and data-out reads 1.
- R12: After the last data bit, one further rising clock returns data-out to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | 8 | Byte offset of the write |
| cfg_wr_data | input | 8 | Write data byte |
| cfg_rd_en | input | 1 | Configuration read in progress |
| cfg_rd_addr | input | 8 | Byte offset of the read |
| cfg_rd_single | input | 1 | 1 when the read is one byte wide |
| cfg_rd_base | input | 8 | Value supplied by the rest of configuration space |
| cfg_rd_data | output | 8 | Read value returned to the bus |

## Verification
Full read commands are driven at the first and last words of each populated region, at an empty word and at the checksum word. Together these show that the image layout, the address bit order and the MSB-first data order are all correct. Variants of the same command separate features that a plain read cannot:
- leading zeros before the start bit;
- repeated clock-high writes during the dummy bit;
- chip-select drops in the middle of the address and in the middle of the data;
- opcodes 11 and 01.

The read path is probed with supplied bytes whose low bit is 0 and whose low bit is 1, at offset 0 and at another offset, and with single-byte and wide reads. This tells masking apart from pass-through.

// File: rtl/eebr_pkg.sv
package eebr_pkg;

    typedef enum logic [2:0] {
        ST_DESEL,
        ST_START,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DONE,
        ST_IGNORE
    } eebr_state_e;

    localparam int SK_BIT = 7;
    localparam int DI_BIT = 6;
    localparam logic [1:0] OP_READ = 2'b10;
    localparam logic [15:0] SUM_TARGET = 16'h1234;

    // Power-on byte values of the fixed image
    localparam logic [7:0] FILL_LO    = 8'h57;
    localparam int         FILL_WORDS = 16;
    localparam logic [7:0] HOST_ID    = 8'h07;
    localparam logic [7:0] MODE_BYTE  = 8'h0F;
    localparam logic [7:0] TAG_DEPTH  = 8'h04;
    localparam logic [7:0] OPT_FLAGS  = 8'h07;

    // Image word before the checksum is placed
    function automatic logic [15:0] image_base(input int idx);
        logic [15:0] w;
        w = 16'h0000;
        if (idx < FILL_WORDS) w = {8'h00, FILL_LO};
        else if (idx == 32)   w = {8'h00, HOST_ID};
        else if (idx == 33)   w = {TAG_DEPTH, MODE_BYTE};
        else if (idx == 34)   w = {8'h00, OPT_FLAGS};
        return w;
    endfunction

    // Checksum word that brings the whole image to SUM_TARGET
    function automatic logic [15:0] image_cksum(input int depth);
        logic [15:0] acc;
        acc = 16'h0000;
        for (int i = 0; i < depth - 1; i++) acc = acc + image_base(i);
        return SUM_TARGET - acc;
    endfunction

endpackage

// File: rtl/eebr_pins.sv
module eebr_pins #(
    parameter int          AW        = 8,
    parameter logic [7:0]  CTRL_OFF  = 8'h80,
    parameter logic [7:0]  DESEL_OFF = 8'hC0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_sk,
    input  logic          wr_di,
    output logic          pin_cs,
    output logic          pin_sk,
    output logic          pin_di
);

    logic hit_ctrl;
    logic hit_desel;

    assign hit_ctrl  = wr_en && (wr_addr == AW'(CTRL_OFF));
    assign hit_desel = wr_en && (wr_addr == AW'(DESEL_OFF));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_cs <= 1'b0;
            pin_sk <= 1'b0;
            pin_di <= 1'b0;
        end else if (hit_ctrl) begin
            pin_cs <= 1'b1;
            pin_sk <= wr_sk;
            pin_di <= wr_di;
        end else if (hit_desel) begin
            pin_cs <= 1'b0;
            pin_sk <= 1'b0;
            pin_di <= 1'b0;
        end
    end

endmodule

// File: rtl/eebr_prom.sv
module eebr_prom
    import eebr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o
);

    localparam int WORDS  = 1 << ADDR_W;
    localparam int CNT_W  = $clog2((DATA_W > ADDR_W) ? DATA_W : ADDR_W) + 1;
    localparam logic [15:0] CKSUM = image_cksum(WORDS);

    eebr_state_e         state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [1:0]          op_q, op_d;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic [DATA_W-1:0]   data_q, data_d;
    logic                sk_prev;
    logic                rise;

    function automatic logic [DATA_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
        if (int'(a) == WORDS - 1) return DATA_W'(CKSUM);
        return DATA_W'(image_base(int'(a)));
    endfunction

    assign rise = cs && sk && !sk_prev;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        op_d    = op_q;
        addr_d  = addr_q;
        data_d  = data_q;
        if (!cs) begin
            state_d = ST_DESEL;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_DESEL: begin
                    cnt_d   = '0;
                    state_d = (rise && di) ? ST_OPCODE : ST_START;
                end
                ST_START: begin
                    if (rise && di) begin
                        state_d = ST_OPCODE;
                        cnt_d   = '0;
                    end
                end
                ST_OPCODE: begin
                    if (rise) begin
                        op_d = {op_q[0], di};
                        if (cnt_q == CNT_W'(1)) begin
                            cnt_d   = '0;
                            state_d = ({op_q[0], di} == OP_READ) ? ST_ADDR : ST_IGNORE;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        addr_d = {addr_q[ADDR_W-2:0], di};
                        if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                            cnt_d   = '0;
                            data_d  = rom_word({addr_q[ADDR_W-2:0], di});
                            state_d = ST_DUMMY;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_DUMMY: begin
                    if (rise) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end
                end
                ST_DATA: begin
                    if (rise) begin
                        if (cnt_q == CNT_W'(DATA_W - 1)) begin
                            state_d = ST_DONE;
                            cnt_d   = '0;
                        end else begin
                            data_d = {data_q[DATA_W-2:0], 1'b0};
                            cnt_d  = cnt_q + 1'b1;
                        end
                    end
                end
                ST_DONE:   state_d = ST_DONE;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_DESEL;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            cnt_q   <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            sk_prev <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            op_q    <= op_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
            sk_prev <= sk;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_DUMMY: do_o = 1'b0;
            ST_DATA:  do_o = data_q[DATA_W-1];
            default:  do_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/eebr_rdmux.sv
module eebr_rdmux #(
    parameter int         AW        = 8,
    parameter logic [7:0] PROBE_OFF = 8'h00
) (
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_single,
    input  logic [7:0]    rd_base,
    input  logic          ee_do,
    output logic [7:0]    rd_data
);

    logic probe_hit;

    assign probe_hit = rd_en && rd_single && (rd_addr == AW'(PROBE_OFF));

    always_comb begin
        rd_data = rd_base;
        if (probe_hit) rd_data[0] = rd_base[0] & ee_do;
    end

endmodule

// File: rtl/cfg_eeprom_bridge.sv
module cfg_eeprom_bridge
    import eebr_pkg::*;
#(
    parameter int         CFG_AW    = 8,
    parameter logic [7:0] CTRL_OFF  = 8'h80,
    parameter logic [7:0] DESEL_OFF = 8'hC0,
    parameter logic [7:0] PROBE_OFF = 8'h00,
    parameter int         ADDR_W    = 6,
    parameter int         DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [7:0]        cfg_wr_data,
    input  logic              cfg_rd_en,
    input  logic [CFG_AW-1:0] cfg_rd_addr,
    input  logic              cfg_rd_single,
    input  logic [7:0]        cfg_rd_base,
    output logic [7:0]        cfg_rd_data
);

    logic ee_cs;
    logic ee_sk;
    logic ee_di;
    logic ee_do;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{cfg_wr_data[5:0]};

    eebr_pins #(
        .AW        (CFG_AW),
        .CTRL_OFF  (CTRL_OFF),
        .DESEL_OFF (DESEL_OFF)
    ) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_sk   (cfg_wr_data[SK_BIT]),
        .wr_di   (cfg_wr_data[DI_BIT]),
        .pin_cs  (ee_cs),
        .pin_sk  (ee_sk),
        .pin_di  (ee_di)
    );

    eebr_prom #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_prom (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (ee_cs),
        .sk    (ee_sk),
        .di    (ee_di),
        .do_o  (ee_do)
    );

    eebr_rdmux #(
        .AW        (CFG_AW),
        .PROBE_OFF (PROBE_OFF)
    ) u_rdmux (
        .rd_en     (cfg_rd_en),
        .rd_addr   (cfg_rd_addr),
        .rd_single (cfg_rd_single),
        .rd_base   (cfg_rd_base),
        .ee_do     (ee_do),
        .rd_data   (cfg_rd_data)
    );

endmodule

// File: rtl/cfg_eeprom_bridge_chk.sv
module cfg_eeprom_bridge_chk #(
    parameter int         CFG_AW    = 8,
    parameter logic [7:0] CTRL_OFF  = 8'h80,
    parameter logic [7:0] DESEL_OFF = 8'hC0,
    parameter logic [7:0] PROBE_OFF = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_wr_addr,
    input logic [7:0]        cfg_wr_data,
    input logic              cfg_rd_en,
    input logic [CFG_AW-1:0] cfg_rd_addr,
    input logic              cfg_rd_single,
    input logic [7:0]        cfg_rd_base,
    input logic [7:0]        cfg_rd_data,
    input logic              ee_cs,
    input logic              ee_sk,
    input logic              ee_di,
    input logic              ee_do
);

    logic probe;
    assign probe = cfg_rd_en && cfg_rd_single && (cfg_rd_addr == CFG_AW'(PROBE_OFF));

    // R1
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == CFG_AW'(CTRL_OFF))
        |=> (ee_cs && ee_sk == $past(cfg_wr_data[7]) && ee_di == $past(cfg_wr_data[6])));

    // R2
    desel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == CFG_AW'(DESEL_OFF)) |=> (!ee_cs && !ee_sk && !ee_di));

    // R3
    probe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe |-> (cfg_rd_data[7:1] == cfg_rd_base[7:1] && cfg_rd_data[0] == (cfg_rd_base[0] && ee_do)));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !probe |-> (cfg_rd_data == cfg_rd_base));

    // R8
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |=> ee_do);

    // R7
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> ($stable(ee_sk) && $stable(ee_cs)));

endmodule

bind cfg_eeprom_bridge cfg_eeprom_bridge_chk #(
    .CFG_AW    (CFG_AW),
    .CTRL_OFF  (CTRL_OFF),
    .DESEL_OFF (DESEL_OFF),
    .PROBE_OFF (PROBE_OFF)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_addr   (cfg_wr_addr),
    .cfg_wr_data   (cfg_wr_data),
    .cfg_rd_en     (cfg_rd_en),
    .cfg_rd_addr   (cfg_rd_addr),
    .cfg_rd_single (cfg_rd_single),
    .cfg_rd_base   (cfg_rd_base),
    .cfg_rd_data   (cfg_rd_data),
    .ee_cs         (ee_cs),
    .ee_sk         (ee_sk),
    .ee_di         (ee_di),
    .ee_do         (ee_do)
);

// File: tb/cfg_eeprom_bridge_test.sv
module cfg_eeprom_bridge_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       rd_single = 1'b0;
    logic [7:0] rd_base = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cfg_eeprom_bridge uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (wr_en),
        .cfg_wr_addr   (wr_addr),
        .cfg_wr_data   (wr_data),
        .cfg_rd_en     (rd_en),
        .cfg_rd_addr   (rd_addr),
        .cfg_rd_single (rd_single),
        .cfg_rd_base   (rd_base),
        .cfg_rd_data   (rd_data)
    );

    typedef struct packed {
        logic [5:0]  addr;
        logic [15:0] word;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{6'd0,  16'h0057}, '{6'd15, 16'h0057}, '{6'd16, 16'h0000},
        '{6'd31, 16'h0000}, '{6'd32, 16'h0007}, '{6'd33, 16'h040F},
        '{6'd34, 16'h0007}, '{6'd35, 16'h0000}, '{6'd62, 16'h0000},
        '{6'd63, 16'h08A7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        cfg_write(8'h80, {1'b0, b, 6'b0});
        cfg_write(8'h80, {1'b1, b, 6'b0});
    endtask

    task automatic probe(input logic [7:0] a, input logic single, input logic [7:0] base,
                         output logic [7:0] r);
        rd_en = 1'b1; rd_addr = a; rd_single = single; rd_base = base;
        #2;
        r = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic get_do(output logic b);
        logic [7:0] r;
        probe(8'h00, 1'b1, 8'hFF, r);
        b = r[0];
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [5:0] a);
        clk_bit(1'b1);
        clk_bit(op[1]);
        clk_bit(op[0]);
        for (int i = 5; i >= 0; i--) clk_bit(a[i]);
    endtask

    task automatic shift_word(output logic [15:0] w);
        logic b;
        w = '0;
        for (int i = 0; i < 16; i++) begin
            clk_bit(1'b0);
            get_do(b);
            w = {w[14:0], b};
        end
    endtask

    task automatic read_word(input logic [5:0] a, input int lead,
                             output logic [15:0] w, output logic dummy);
        cfg_write(8'hC0, 8'h00);
        for (int i = 0; i < lead; i++) clk_bit(1'b0);
        send_cmd(2'b10, a);
        get_do(dummy);
        shift_word(w);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [15:0] sum;
        logic        b;
        logic        d;
        logic [7:0]  r;
        int          ones;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: reset state, data-out high
        probe(8'h00, 1'b1, 8'hFF, r);
        check("R11 reset data-out", r, 8'hFF);

        // R5 R1 R10: table of reads
        for (int k = 0; k < NVEC; k++) begin
            read_word(VECS[k].addr, 0, w, d);
            check("R5 dummy bit", d, 1'b0);
            check("R10 R1 image word", w, VECS[k].word);
        end

        // R10: whole image sums to 0x1234
        sum = '0;
        for (int a = 0; a < 64; a++) begin
            read_word(6'(a), 0, w, d);
            sum = sum + w;
        end
        check("R10 image sum", sum, 16'h1234);

        // R3 R4: read path during the dummy bit (data-out = 0)
        cfg_write(8'hC0, 8'h00);
        send_cmd(2'b10, 6'd32);
        probe(8'h00, 1'b1, 8'hFF, r);
        check("R3 masked bit0", r, 8'hFE);
        probe(8'h00, 1'b1, 8'hA4, r);
        check("R3 base bit0 zero", r, 8'hA4);
        probe(8'h04, 1'b1, 8'hA5, r);
        check("R4 other offset", r, 8'hA5);
        probe(8'h00, 1'b0, 8'hFF, r);
        check("R4 wide read", r, 8'hFF);

        // R7: repeated clock-high writes do not shift
        for (int i = 0; i < 3; i++) cfg_write(8'h80, 8'hC0);
        get_do(b);
        check("R7 still dummy", b, 1'b0);
        shift_word(w);
        check("R7 word intact", w, 16'h0007);

        // R12: data-out returns high after the last bit
        clk_bit(1'b0);
        get_do(b);
        check("R12 done high", b, 1'b1);
        clk_bit(1'b0);
        get_do(b);
        check("R12 stays high", b, 1'b1);

        // R6: leading zeros before the start bit
        read_word(6'd33, 3, w, d);
        check("R6 leading zeros", w, 16'h040F);

        // R8 R2: drop chip select mid-data while data-out is 0
        cfg_write(8'hC0, 8'h00);
        send_cmd(2'b10, 6'd0);
        clk_bit(1'b0);
        get_do(b);
        check("R5 first data bit", b, 1'b0);
        cfg_write(8'hC0, 8'h00);
        get_do(b);
        check("R2 R8 release idles high", b, 1'b1);
        read_word(6'd63, 0, w, d);
        check("R8 read after abort", w, 16'h08A7);

        // R8: abort in the middle of the address
        cfg_write(8'hC0, 8'h00);
        clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b0);
        read_word(6'd34, 0, w, d);
        check("R8 mid-address abort", w, 16'h0007);

        // R9: non-read opcodes keep data-out high
        cfg_write(8'hC0, 8'h00);
        send_cmd(2'b11, 6'd0);
        ones = 0;
        for (int i = 0; i < 17; i++) begin
            get_do(b);
            if (b) ones++;
            clk_bit(1'b0);
        end
        check("R9 opcode 11 high", ones, 17);
        cfg_write(8'hC0, 8'h00);
        send_cmd(2'b01, 6'd32);
        ones = 0;
        for (int i = 0; i < 17; i++) begin
            get_do(b);
            if (b) ones++;
            clk_bit(1'b0);
        end
        check("R9 opcode 01 high", ones, 17);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule